// File: doc/BRIEF.md
# DDS Command Word Decoder

This block sits between a serial word receiver and a direct digital synthesis core. Each 16-bit command word carries a two-bit destination code in its top bits. The block uses that code to route the word into one of its registers: a control register, two 28-bit frequency tuning registers or two 12-bit phase offset registers. The synthesis core reads every register value and every decoded control field directly from the block's outputs.

A frequency tuning value can be written in two ways, and the control register picks which. In full-word mode, two writes to the same frequency address deliver the low and then the high 14-bit half. The register takes both halves together on the second write, so it never holds a mix of old and new bits. In half mode, each frequency write replaces only one 14-bit half. This gives coarse or fine tuning without touching the other half.

All storage is cleared by the block's synchronous hardware reset. The reset field inside the control register is only passed through to the core and clears nothing here.

Top module: `dds_cmd_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, all registers and any pending low half are cleared to zero, so every output reads zero after that edge.
- R2: An accepted word with bits 15:14 = 00 stores bits 13:0 into control register bits 13:0. Control register bits 15:14 always read 0.
- R3: An accepted word with bits 15:14 = 11 writes bits 11:0 into phase register 0 when bit 13 = 0, or into phase register 1 when bit 13 = 1. Bit 12 has no effect.
- R4: When control bit 13 is 1 (full-word mode), a frequency write (01 = register 0, 10 = register 1) with no pending half for that address holds bits 13:0 as a pending low half. The next write to the same address loads {its bits 13:0, pending half} into all 28 bits.
- R5: In full-word mode the addressed frequency register does not change on the first word of a pair.
- R6: A pending low half is dropped when the next accepted word is not a frequency write to the same address. That word is processed normally, and if it is a frequency write to the other address it becomes a new first half.
- R7: A control register write clears any pending low half.
- R8: When control bit 13 is 0, a frequency write with control bit 12 = 1 replaces bits 27:14 and with bit 12 = 0 replaces bits 13:0, leaving the other half unchanged. In full-word mode bit 12 has no effect.
- R9: Setting control bit 8 (the core reset field) clears no frequency, phase or control register.
- R10: The decoded outputs follow control register bits: 13 full-word mode, 12 half select, 11 frequency select, 10 phase select, 8 core reset, 7 clock halt, 6 DAC power-down, 5 digital output enable, 3 divide-by-two, 1 waveform mode.
- R11: Words presented while `word_valid` is low change no register and no pending state.
- R12: An accepted word takes effect on the clock edge that samples it and is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Command word present this cycle |
| word_data | input | 16 | Command word |
| ctrl_reg | output | 16 | Control register contents |
| freq0 | output | 28 | Frequency register 0 |
| freq1 | output | 28 | Frequency register 1 |
| phase0 | output | 12 | Phase register 0 |
| phase1 | output | 12 | Phase register 1 |
| full_word_mode | output | 1 | Control bit 13 |
| half_hi_sel | output | 1 | Control bit 12 |
| freq_sel | output | 1 | Control bit 11 |
| phase_sel | output | 1 | Control bit 10 |
| core_reset | output | 1 | Control bit 8 |
| clk_halt | output | 1 | Control bit 7 |
| dac_off | output | 1 | Control bit 6 |
| dig_out_en | output | 1 | Control bit 5 |
| div2_sel | output | 1 | Control bit 3 |
| wave_mode | output | 1 | Control bit 1 |

## Verification
The hardest situation to reach is a broken pair in full-word mode. A low half must be pending when a word arrives that is a phase write, a control write or a frequency write to the other address. The effect is visible only through what a later write to the original address loads. Directed sequences build each kind of interruption and then complete a pair to expose any stale half. The random stream keeps full-word mode on most of the time and draws frequency addresses heavily, so that broken and back-to-back pairs occur often.

// File: rtl/dds_cmd_pkg.sv
package dds_cmd_pkg;
  typedef enum logic [1:0] {
    DST_CTRL  = 2'b00,
    DST_FREQ0 = 2'b01,
    DST_FREQ1 = 2'b10,
    DST_PHASE = 2'b11
  } dest_e;

  localparam int CB_FULL   = 13;
  localparam int CB_HALF   = 12;
  localparam int CB_FSEL   = 11;
  localparam int CB_PSEL   = 10;
  localparam int CB_CRST   = 8;
  localparam int CB_HALT   = 7;
  localparam int CB_DACOFF = 6;
  localparam int CB_DIGOUT = 5;
  localparam int CB_DIV2   = 3;
  localparam int CB_MODE   = 1;
  localparam int PH_IDX_BIT = 13;
endpackage

// File: rtl/dds_word_router.sv
module dds_word_router
  import dds_cmd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output logic              ctrl_we,
  output logic              freq_we,
  output logic              freq_idx,
  output logic              phase_we,
  output logic              phase_idx
);
  localparam int DST_LO = WORD_W - 2;

  dest_e dst;

  always_comb begin
    dst       = dest_e'(word[WORD_W-1:DST_LO]);
    ctrl_we   = valid && (dst == DST_CTRL);
    freq_we   = valid && ((dst == DST_FREQ0) || (dst == DST_FREQ1));
    freq_idx  = (dst == DST_FREQ1);
    phase_we  = valid && (dst == DST_PHASE);
    phase_idx = word[PH_IDX_BIT];
  end
endmodule

// File: rtl/dds_freq_loader.sv
module dds_freq_loader #(
  parameter int FREQ_W = 28,
  parameter int NUM    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       full_mode,
  input  logic                       hi_sel,
  input  logic                       we,
  input  logic [$clog2(NUM)-1:0]     idx,
  input  logic [FREQ_W/2-1:0]        payload,
  input  logic                       flush,
  output logic [NUM-1:0][FREQ_W-1:0] freq_q
);
  localparam int HALF_W = FREQ_W / 2;
  localparam int IDX_W  = $clog2(NUM);

  logic              pend_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic [HALF_W-1:0] pend_lo_q;
  logic              pair_done;

  assign pair_done = we && full_mode && pend_q && (pend_idx_q == idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      pend_lo_q  <= '0;
    end else if (flush) begin
      pend_q <= 1'b0;
    end else if (we) begin
      if (full_mode && !pair_done) begin
        pend_q     <= 1'b1;
        pend_idx_q <= idx;
        pend_lo_q  <= payload;
      end else begin
        pend_q <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM; g++) begin : g_freq
    always_ff @(posedge clk) begin
      if (rst) begin
        freq_q[g] <= '0;
      end else if (we && (idx == IDX_W'(g))) begin
        if (full_mode) begin
          if (pair_done) freq_q[g] <= {payload, pend_lo_q};
        end else if (hi_sel) begin
          freq_q[g][FREQ_W-1:HALF_W] <= payload;
        end else begin
          freq_q[g][HALF_W-1:0] <= payload;
        end
      end
    end
  end

  // R5
  first_half_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (we && full_mode && !(pend_q && pend_idx_q == idx)) |=> $stable(freq_q));
  // R7
  flush_clr_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !pend_q);
  // R11
  freq_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(freq_q));
endmodule

// File: rtl/dds_phase_bank.sv
module dds_phase_bank #(
  parameter int PHASE_W = 12,
  parameter int NUM     = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [$clog2(NUM)-1:0]      idx,
  input  logic [PHASE_W-1:0]          value,
  output logic [NUM-1:0][PHASE_W-1:0] ph_q
);
  localparam int IDX_W = $clog2(NUM);

  for (genvar g = 0; g < NUM; g++) begin : g_ph
    always_ff @(posedge clk) begin
      if (rst) ph_q[g] <= '0;
      else if (we && (idx == IDX_W'(g))) ph_q[g] <= value;
    end
  end

  // R3
  phase_store_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (ph_q[$past(idx)] == $past(value)));
  // R11
  phase_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(ph_q));
endmodule

// File: rtl/dds_cmd_decoder.sv
module dds_cmd_decoder
  import dds_cmd_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int FREQ_W  = 28,
  parameter int PHASE_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word_valid,
  input  logic [WORD_W-1:0]  word_data,
  output logic [WORD_W-1:0]  ctrl_reg,
  output logic [FREQ_W-1:0]  freq0,
  output logic [FREQ_W-1:0]  freq1,
  output logic [PHASE_W-1:0] phase0,
  output logic [PHASE_W-1:0] phase1,
  output logic               full_word_mode,
  output logic               half_hi_sel,
  output logic               freq_sel,
  output logic               phase_sel,
  output logic               core_reset,
  output logic               clk_halt,
  output logic               dac_off,
  output logic               dig_out_en,
  output logic               div2_sel,
  output logic               wave_mode
);
  localparam int HALF_W = FREQ_W / 2;
  localparam int BODY_W = WORD_W - 2;

  logic ctrl_we, freq_we, freq_idx, phase_we, phase_idx;
  logic [WORD_W-1:0] ctrl_q;
  logic [1:0][FREQ_W-1:0]  freq_arr;
  logic [1:0][PHASE_W-1:0] ph_arr;

  dds_word_router #(.WORD_W(WORD_W)) u_router (
    .valid     (word_valid),
    .word      (word_data),
    .ctrl_we   (ctrl_we),
    .freq_we   (freq_we),
    .freq_idx  (freq_idx),
    .phase_we  (phase_we),
    .phase_idx (phase_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= {2'b00, word_data[BODY_W-1:0]};
  end

  dds_freq_loader #(.FREQ_W(FREQ_W), .NUM(2)) u_freq (
    .clk       (clk),
    .rst       (rst),
    .full_mode (ctrl_q[CB_FULL]),
    .hi_sel    (ctrl_q[CB_HALF]),
    .we        (freq_we),
    .idx       (freq_idx),
    .payload   (word_data[HALF_W-1:0]),
    .flush     (ctrl_we || phase_we),
    .freq_q    (freq_arr)
  );

  dds_phase_bank #(.PHASE_W(PHASE_W), .NUM(2)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .we    (phase_we),
    .idx   (phase_idx),
    .value (word_data[PHASE_W-1:0]),
    .ph_q  (ph_arr)
  );

  assign ctrl_reg       = ctrl_q;
  assign freq0          = freq_arr[0];
  assign freq1          = freq_arr[1];
  assign phase0         = ph_arr[0];
  assign phase1         = ph_arr[1];
  assign full_word_mode = ctrl_q[CB_FULL];
  assign half_hi_sel    = ctrl_q[CB_HALF];
  assign freq_sel       = ctrl_q[CB_FSEL];
  assign phase_sel      = ctrl_q[CB_PSEL];
  assign core_reset     = ctrl_q[CB_CRST];
  assign clk_halt       = ctrl_q[CB_HALT];
  assign dac_off        = ctrl_q[CB_DACOFF];
  assign dig_out_en     = ctrl_q[CB_DIGOUT];
  assign div2_sel       = ctrl_q[CB_DIV2];
  assign wave_mode      = ctrl_q[CB_MODE];

  // R2
  ctrl_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_reg[WORD_W-1:BODY_W] == 2'b00);
  // R11
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(word_valid && word_data[WORD_W-1:BODY_W] == 2'b00) |=> $stable(ctrl_reg));
  // R9
  core_reset_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (core_reset && !word_valid) |=> ($stable(freq0) && $stable(phase0)));
endmodule

// File: tb/dds_cmd_decoder_bench.sv
module dds_cmd_decoder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic [15:0] ctrl_reg;
  logic [27:0] freq0, freq1;
  logic [11:0] phase0, phase1;
  logic full_word_mode, half_hi_sel, freq_sel, phase_sel, core_reset;
  logic clk_halt, dac_off, dig_out_en, div2_sel, wave_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_ctrl;
  logic [27:0] m_f [2];
  logic [11:0] m_p [2];
  bit          m_pend;
  int          m_pidx;
  logic [13:0] m_plo;

  always #2 clk = ~clk;

  dds_cmd_decoder u_dds_cmd_decoder (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
    .ctrl_reg(ctrl_reg), .freq0(freq0), .freq1(freq1),
    .phase0(phase0), .phase1(phase1),
    .full_word_mode(full_word_mode), .half_hi_sel(half_hi_sel),
    .freq_sel(freq_sel), .phase_sel(phase_sel), .core_reset(core_reset),
    .clk_halt(clk_halt), .dac_off(dac_off), .dig_out_en(dig_out_en),
    .div2_sel(div2_sel), .wave_mode(wave_mode)
  );

  function automatic logic [9:0] exp_fields(logic [15:0] c);
    return {c[13], c[12], c[11], c[10], c[8], c[7], c[6], c[5], c[3], c[1]};
  endfunction

  task automatic model_reset();
    m_ctrl = '0; m_f[0] = '0; m_f[1] = '0; m_p[0] = '0; m_p[1] = '0;
    m_pend = 0; m_pidx = 0; m_plo = '0;
  endtask

  task automatic model_apply(logic [15:0] w);
    int a;
    case (w[15:14])
      2'b00: begin m_ctrl = {2'b00, w[13:0]}; m_pend = 0; end
      2'b11: begin m_p[w[13]] = w[11:0]; m_pend = 0; end
      default: begin
        a = (w[15:14] == 2'b10) ? 1 : 0;
        if (m_ctrl[13]) begin
          if (m_pend && m_pidx == a) begin
            m_f[a] = {w[13:0], m_plo};
            m_pend = 0;
          end else begin
            m_pend = 1; m_pidx = a; m_plo = w[13:0];
          end
        end else begin
          if (m_ctrl[12]) m_f[a][27:14] = w[13:0];
          else m_f[a][13:0] = w[13:0];
          m_pend = 0;
        end
      end
    endcase
  endtask

  task automatic check_all(string tag);
    logic [9:0] got_f;
    got_f = {full_word_mode, half_hi_sel, freq_sel, phase_sel, core_reset,
             clk_halt, dac_off, dig_out_en, div2_sel, wave_mode};
    checks++;
    if (ctrl_reg !== m_ctrl || freq0 !== m_f[0] || freq1 !== m_f[1] ||
        phase0 !== m_p[0] || phase1 !== m_p[1] || got_f !== exp_fields(m_ctrl)) begin
      errors++;
      $display("FAIL %s ctrl=%h f0=%h f1=%h p0=%h p1=%h fld=%b exp ctrl=%h f0=%h f1=%h p0=%h p1=%h fld=%b",
               tag, ctrl_reg, freq0, freq1, phase0, phase1, got_f,
               m_ctrl, m_f[0], m_f[1], m_p[0], m_p[1], exp_fields(m_ctrl));
    end
  endtask

  // R12: word driven at negedge, sampled by the next posedge, checked at the following negedge
  task automatic send(logic [15:0] w, string tag);
    word_valid = 1'b1; word_data = w;
    @(negedge clk);
    word_valid = 1'b0;
    model_apply(w);
    check_all(tag);
  endtask

  task automatic idle(logic [15:0] w, string tag);
    word_valid = 1'b0; word_data = w;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset state");

    // R8 half mode, high then low halves
    send(16'h1000, "R2 control write half-high");
    send(16'h4000 | 16'h2ABC, "R8 high half freq0");
    send(16'h0000, "R2 control write half-low");
    send(16'h4000 | 16'h1234, "R8 low half freq0");
    send(16'h8000 | 16'h3FFF, "R8 low half freq1");
    // R3 phase writes, bit 12 ignored
    send(16'hC000 | 16'h1ABC, "R3 phase0 with bit12 set");
    send(16'hE000 | 16'h0123, "R3 phase1");
    // R10 field decode
    send(16'h3DEA, "R10 fields pattern a");
    send(16'h0215, "R10 fields pattern b");
    // R4 R5 full-word pair
    send(16'h2000, "R2 enter full mode");
    send(16'h4000 | 16'h0555, "R5 first half holds freq0");
    send(16'h4000 | 16'h2AAA, "R4 pair completes freq0");
    // R8 bit 12 ignored in full mode
    send(16'h3000, "R8 full mode with half bit");
    send(16'h8000 | 16'h0001, "R5 first half freq1");
    send(16'h8000 | 16'h0002, "R4 pair freq1 ignores half bit");
    // R6 interrupted by phase write
    send(16'h2000, "R2 full mode");
    send(16'h4000 | 16'h0111, "R5 first half");
    send(16'hC000 | 16'h0777, "R6 phase interrupts pair");
    send(16'h4000 | 16'h0222, "R6 new first half after drop");
    send(16'h4000 | 16'h0333, "R6 pair after drop");
    // R6 interrupted by the other frequency address
    send(16'h4000 | 16'h0AAA, "R5 first half freq0");
    send(16'h8000 | 16'h0BBB, "R6 other address becomes first half");
    send(16'h8000 | 16'h0CCC, "R6 completes freq1 pair");
    // R7 control write clears pending
    send(16'h4000 | 16'h0DDD, "R5 first half");
    send(16'h2000, "R7 control clears pending");
    send(16'h4000 | 16'h0EEE, "R7 restarts as first half");
    send(16'h4000 | 16'h0FFF, "R7 pair after clear");
    // R9 core reset field clears nothing
    send(16'h0100, "R9 core reset set");
    idle(16'h0000, "R9 registers kept under core reset");
    // R11 words with valid low ignored
    idle(16'h4000 | 16'h1111, "R11 ignored freq word");
    idle(16'h0000, "R11 ignored control word");
    idle(16'hC000 | 16'h0999, "R11 ignored phase word");

    // mixed random stream
    process::self().srandom(32'd1234);
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] w;
      int r;
      r = $urandom_range(0, 99);
      w = 16'($urandom);
      if (r < 8) w[15:14] = 2'b00;
      else if (r < 80) w[15:14] = (r < 44) ? 2'b01 : 2'b10;
      else w[15:14] = 2'b11;
      if (w[15:14] == 2'b00 && $urandom_range(0, 3) != 0) w[13] = 1'b1;
      if ($urandom_range(0, 9) == 0) idle(w, "R11 random idle");
      else send(w, "R4 R6 R8 random stream");
    end

    // R1 reset mid-stream with a pending half
    send(16'h2000, "R2 full mode before reset");
    send(16'h4000 | 16'h0123, "R5 pending before reset");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    check_all("R1 reset clears all");
    send(16'h4000 | 16'h0456, "R1 no stale pending after reset");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule